// File: doc/BRIEF.md
# I2C Slave with Buffered Transmit and Receive Registers

This block is the target side of a two-wire serial bus and has a byte-wide register port for the CPU. SCL and SDA each pass through a two-flop synchronizer. The block then detects START, repeated START and STOP, and shifts in an address byte. It claims the transfer when the seven address bits equal `own_addr`. The eighth bit of the address byte gives the direction. A 1 means the bus master reads from this slave.

When the master writes, each incoming byte goes MSB first into a shifter. On completion the byte moves to `rx_data` and the slave acknowledges it. When the master reads, bytes come from a transmit holding register that the CPU writes. That register is double-buffered against a separate output shifter. A copy into the shifter happens only at a matched read address or after the master has acknowledged the previous byte. A master NACK leaves the holding register untouched until this slave is addressed again. SDA is driven open-drain: `sda_oe` high pulls the line low.

The system clock must run at least four times faster than SCL.

Top module: `i2c_slave_buf`

## Requirements
- R1: After reset, `rxbf`, `txbe`, `match`, `srw`, `rxak` and `sda_oe` are all 0. The transmit holding register holds 0xFF, so the first byte a master reads without a prior CPU write is 0xFF.
- R2: After a START, the first eight SDA bits sampled on SCL rising edges form the address byte, MSB first. `match` sets only when the first seven bits equal `own_addr`. `srw` takes the eighth bit, where 1 means read.
- R3: The slave pulls SDA low during the ninth clock after a matching address byte. It leaves SDA released when the address does not match.
- R4: In a write transfer, each completed byte is placed on `rx_data` MSB first and `rxbf` sets. The slave pulls SDA low during that byte's ninth clock.
- R5: A one-cycle `rd_rx` pulse clears `rxbf`.
- R6: On a matched address with read, the holding register is copied into the output shifter and `txbe` sets. The byte is then sent MSB first.
- R7: A `wr_tx` pulse loads `wdata` into the holding register and clears `txbe`.
- R8: When the master returns ACK (SDA 0) after a sent byte, `rxak` becomes 0. The holding register is then copied into the shifter and sent as the next byte.
- R9: When the master returns NACK (SDA 1), `rxak` becomes 1 and SDA stays released. No copy takes place, so `txbe` keeps its value of 0. The byte written meanwhile is the first one sent after the next matching read call.
- R10: A STOP clears `match`, releases SDA and returns the controller to idle.
- R11: While `en` is 0, the slave ignores the bus, never drives SDA, and ignores CPU writes to the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| own_addr | input | 7 | Slave address compared with the calling address |
| wr_tx | input | 1 | CPU write strobe for the transmit holding register |
| wdata | input | 8 | CPU write data |
| rd_rx | input | 1 | CPU read strobe for the receive register, clears `rxbf` |
| rx_data | output | 8 | Receive holding register |
| rxbf | output | 1 | Receive buffer full |
| txbe | output | 1 | Transmit buffer empty (holding register copied to shifter) |
| match | output | 1 | Address matched in the current transfer |
| srw | output | 1 | Direction bit of the last matched address, 1 = read |
| rxak | output | 1 | Last acknowledge bit received from the master |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Bus events reach the controller about three system clocks after a line change: two synchronizer flops plus the edge register. `match`, `srw` and `rx_data` are therefore valid a few clocks after the relevant SCL rising edge. ACK and data drive appear a few clocks after an SCL falling edge. The bench holds every SCL phase for ten system clocks. It samples SDA at the middle of SCL high and reads flags only after a whole bit or byte has finished. CPU-strobe effects (`rxbf` cleared, `txbe` cleared) are due one clock after the strobe and are checked on the following falling clock edge.

// File: rtl/i2c_slave_buf.sv
module i2c_slave_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [6:0] own_addr,
  input  logic       wr_tx,
  input  logic [7:0] wdata,
  input  logic       rd_rx,
  output logic [7:0] rx_data,
  output logic       rxbf,
  output logic       txbe,
  output logic       match,
  output logic       srw,
  output logic       rxak,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);

  typedef enum logic [2:0] {IDLE, ADDR, ACK, ACKD, RX, TX, MACK} st_t;
  st_t st;

  logic [1:0] scl_sy, sda_sy;
  logic       p_scl, p_sda;
  logic [2:0] cnt;
  logic [7:0] sh, osh, txh;

  wire s_scl = scl_sy[1];
  wire s_sda = sda_sy[1];
  wire scl_rise = s_scl & ~p_scl;
  wire scl_fall = ~s_scl & p_scl;
  wire start_det = s_scl & p_scl & p_sda & ~s_sda;
  wire stop_det  = s_scl & p_scl & ~p_sda & s_sda;

  wire ld_addr = en && st == ADDR && scl_rise && cnt == 3'd7 && sh[6:0] == own_addr && s_sda;
  wire ld_ack  = en && st == MACK && scl_rise && !s_sda;
  wire ld      = ld_addr | ld_ack;
  wire rx_done = en && st == RX && scl_rise && cnt == 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; p_scl <= 1'b1; p_sda <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      p_scl  <= s_scl;
      p_sda  <= s_sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; osh <= '0; rx_data <= '0;
      match <= 1'b0; srw <= 1'b0; rxak <= 1'b0; sda_oe <= 1'b0;
    end else if (!en) begin
      st <= IDLE; match <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= ADDR; cnt <= '0; match <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= IDLE; match <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (ld) osh <= txh;
      case (st)
        ADDR: if (scl_rise) begin
          sh  <= {sh[6:0], s_sda};
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (sh[6:0] == own_addr) begin
              match <= 1'b1; srw <= s_sda; st <= ACK;
            end else st <= IDLE;
          end
        end
        ACK: if (scl_fall) begin
          sda_oe <= 1'b1; st <= ACKD;
        end
        ACKD: if (scl_fall) begin
          cnt <= '0;
          if (srw) begin st <= TX; sda_oe <= ~osh[7]; end
          else     begin st <= RX; sda_oe <= 1'b0;    end
        end
        RX: if (scl_rise) begin
          sh  <= {sh[6:0], s_sda};
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            rx_data <= {sh[6:0], s_sda}; st <= ACK;
          end
        end
        TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_oe <= 1'b0; st <= MACK; cnt <= '0;
          end else begin
            osh <= {osh[6:0], 1'b1}; sda_oe <= ~osh[6]; cnt <= cnt + 3'd1;
          end
        end
        MACK: if (scl_rise) begin
          rxak <= s_sda;
          st   <= s_sda ? IDLE : ACKD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txh <= 8'hFF; txbe <= 1'b0; rxbf <= 1'b0;
    end else if (en) begin
      if (wr_tx) txh <= wdata;
      if (wr_tx) txbe <= 1'b0;
      else if (ld) txbe <= 1'b1;
      if (rx_done) rxbf <= 1'b1;
      else if (rd_rx) rxbf <= 1'b0;
    end
  end

  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE |-> !sda_oe);
  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_det) |=> !match && st == IDLE);
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !match && !sda_oe);
  p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_rx && !rx_done) |=> !rxbf);
  p_wr_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_tx) |=> !txbe && txh == $past(wdata));
  p_txbe_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txbe) |-> match && srw);
  p_nack_no_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MACK && scl_rise && s_sda && !wr_tx) |=> $stable(txbe) && $stable(osh));

endmodule

// File: tb/sim_i2c_slave_buf.sv
module sim_i2c_slave_buf;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h52;
  localparam int NV = 4;
  localparam logic [15:0] VEC [NV] = '{
    {7'h52, 8'h5A, 1'b0},
    {7'h13, 8'h99, 1'b1},
    {7'h52, 8'h00, 1'b0},
    {7'h53, 8'h3C, 1'b1}
  };

  logic clk = 0, rst_n = 0, en = 0, wr_tx = 0, rd_rx = 0;
  logic [7:0] wdata = 0;
  logic scl = 1, sda_m = 1;
  logic [7:0] rx_data;
  logic rxbf, txbe, match, srw, rxak, sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_slave_buf u0 (.clk(clk), .rst_n(rst_n), .en(en), .own_addr(OWN),
    .wr_tx(wr_tx), .wdata(wdata), .rd_rx(rd_rx), .rx_data(rx_data),
    .rxbf(rxbf), .txbe(txbe), .match(match), .srw(srw), .rxak(rxak),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
  endtask

  task automatic bstop();
    sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic bbit(input logic b, output logic s);
    sda_m = b; wq(); scl = 1; wq(); s = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic bput(input logic [7:0] d, output logic ak);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(d[i], s);
    bbit(1'b1, ak);
  endtask

  task automatic bget(input logic ak, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bbit(1'b1, s); d[i] = s; end
    bbit(ak, s);
  endtask

  task automatic cpu_wr(input logic [7:0] d);
    @(negedge clk); wr_tx = 1; wdata = d; @(negedge clk); wr_tx = 0;
  endtask

  task automatic cpu_rd();
    @(negedge clk); rd_rx = 1; @(negedge clk); rd_rx = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_up();
  end

  initial begin
    logic ak;
    logic [7:0] d, last;
    repeat (3) @(negedge clk);
    rst_n = 1; en = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset flags", {rxbf, txbe, match, srw, rxak, sda_oe}, 6'b0);
    last = 8'h00;

    for (int v = 0; v < NV; v++) begin
      logic hit;
      hit = !VEC[v][0];
      bstart();
      bput({VEC[v][15:9], 1'b0}, ak);
      chk("R3 addr ack", ak, VEC[v][0]);
      chk("R2 match", match, hit);
      if (hit) chk("R2 srw write", srw, 1'b0);
      bput(VEC[v][8:1], ak);
      if (hit) begin
        chk("R4 data ack", ak, 1'b0);
        chk("R4 rx_data", rx_data, VEC[v][8:1]);
        chk("R4 rxbf set", rxbf, 1'b1);
        cpu_rd();
        chk("R5 rxbf clear", rxbf, 1'b0);
        last = VEC[v][8:1];
      end else begin
        chk("R3 nack data", ak, 1'b1);
        chk("R3 rx unchanged", rx_data, last);
        chk("R3 rxbf idle", rxbf, 1'b0);
      end
      bstop();
      repeat (4) @(negedge clk);
      chk("R10 match clear", match, 1'b0);
    end

    bstart();
    bput({OWN, 1'b1}, ak);
    chk("R3 read ack", ak, 1'b0);
    chk("R2 srw read", srw, 1'b1);
    chk("R6 txbe set", txbe, 1'b1);
    cpu_wr(8'h3C);
    chk("R7 txbe clear", txbe, 1'b0);
    bget(1'b0, d);
    chk("R1 reset hold FF", d, 8'hFF);
    chk("R8 rxak ack", rxak, 1'b0);
    chk("R8 txbe reload", txbe, 1'b1);
    cpu_wr(8'h77);
    bget(1'b1, d);
    chk("R8 second byte", d, 8'h3C);
    chk("R9 rxak nack", rxak, 1'b1);
    chk("R9 txbe kept", txbe, 1'b0);
    chk("R9 sda released", sda_oe, 1'b0);
    bstart();
    bput({OWN, 1'b1}, ak);
    chk("R9 recall ack", ak, 1'b0);
    chk("R9 recall txbe", txbe, 1'b1);
    bget(1'b1, d);
    chk("R9 frozen byte", d, 8'h77);
    bstop();
    repeat (4) @(negedge clk);
    chk("R10 after stop", {match, sda_oe}, 2'b00);

    en = 0;
    cpu_wr(8'h11);
    bstart();
    bput({OWN, 1'b0}, ak);
    chk("R11 no ack disabled", ak, 1'b1);
    chk("R11 no match disabled", match, 1'b0);
    bstop();
    en = 1;
    repeat (4) @(negedge clk);
    bstart();
    bput({OWN, 1'b1}, ak);
    bget(1'b1, d);
    chk("R11 write ignored", d, 8'h77);
    bstop();
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule